// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver

This block receives asynchronous serial frames of eight or nine data bits. A line idles high. A frame starts with a low start bit, carries its data bits least significant first, and ends with a high stop bit. The line is sampled once per pulse of an external enable that runs at sixteen times the baud rate. Each bit value comes from a majority vote over three samples taken near the middle of the bit.

A received frame is handed to software through a data byte, a ninth-bit output and a ready flag. It is handed over only when the previous frame has been acknowledged, reception is enabled, and an external accept qualifier agrees. That qualifier comes from a separate address filter. An optional stop-bit check raises a sticky framing-error flag. The check also moves the point at which the ready flag rises, from the last data bit to the stop bit. In 8-bit mode, a multiprocessor control suppresses the ready flag for frames with a bad stop bit.

Top module: `rx_oversample_uart`

## Requirements
- R1: After reset, `rx_ready`, `frame_err`, `rx_bit9` and `rx_byte` are all 0.
- R2: In 8-bit mode (`nine_bit`=0) the frame is one start bit (0), eight data bits LSB first and a stop bit. `rx_byte` holds the data and `rx_bit9` holds the received stop bit.
- R3: In 9-bit mode (`nine_bit`=1) the eight data bits go to `rx_byte` and the ninth received data bit goes to `rx_bit9`.
- R4: A frame starts only on a 1-to-0 change between two consecutive samples taken with `samp_en`=1, while `rx_enable`=1. Line activity between sample pulses is not seen. The sample at which the change is seen is slot 0 of the start bit, and every later bit spans 16 samples.
- R5: Each bit value is the 2-of-3 majority of its slots 7, 8 and 9. A single disturbed sample in those slots does not change the result.
- R6: If the voted start bit is 1, the receiver returns to idle, delivers nothing, and receives the next frame normally.
- R7: With `frame_chk_en`=1, a stop bit voted 0 sets `frame_err`. Later good frames leave it set, and only `clr_fe` (or reset) clears it.
- R8: With `frame_chk_en`=0, a stop bit of 0 never sets `frame_err`.
- R9: In 9-bit mode, `rx_ready` rises at slot 9 of the ninth data bit when `frame_chk_en`=0, and at slot 9 of the stop bit when `frame_chk_en`=1.
- R10: In 8-bit mode with `multi_proc`=1, a frame whose stop bit is 0 does not set `rx_ready`.
- R11: A frame is dropped, leaving `rx_byte`, `rx_bit9` and `rx_ready` unchanged, when `rx_ready` is already 1, when `rx_enable`=0, or when `accept`=0.
- R12: A `clr_ri` pulse clears `rx_ready` in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| samp_en | input | 1 | Sample enable at 16x baud |
| rxd | input | 1 | Serial line |
| rx_enable | input | 1 | Reception enable |
| multi_proc | input | 1 | In 8-bit mode, require a valid stop bit before setting ready |
| nine_bit | input | 1 | 0: 8 data bits, 1: 9 data bits |
| frame_chk_en | input | 1 | Enable stop-bit check and late ready |
| accept | input | 1 | Qualifier from the address filter |
| clr_ri | input | 1 | Pulse that clears `rx_ready` |
| clr_fe | input | 1 | Pulse that clears `frame_err` |
| rx_byte | output | 8 | Last delivered data byte |
| rx_bit9 | output | 1 | Ninth bit or stop bit of the last delivered frame |
| rx_ready | output | 1 | Frame delivered, awaiting acknowledge |
| frame_err | output | 1 | Sticky framing error |

## Verification
The hardest cases to reach from the ports are those that depend on the exact sample slot inside a bit: the majority vote, the false start, and the point at which ready rises. These cannot be forced with a free-running serial model. The bench therefore drives the sample enable and the line itself, one sample at a time. This lets it flip a single sample at slot 7, 8 or 9 of a chosen bit. It also lets it hold the start bit low for only part of the voting window, and probe `rx_ready` four samples into the stop bit.

// File: rtl/rx_oversample_uart.sv
module rx_oversample_uart #(
  parameter int OVS      = 16,
  parameter int VOTE_MID = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       samp_en,
  input  logic       rxd,
  input  logic       rx_enable,
  input  logic       multi_proc,
  input  logic       nine_bit,
  input  logic       frame_chk_en,
  input  logic       accept,
  input  logic       clr_ri,
  input  logic       clr_fe,
  output logic [7:0] rx_byte,
  output logic       rx_bit9,
  output logic       rx_ready,
  output logic       frame_err
);
  localparam int PW = $clog2(OVS);
  localparam logic [PW-1:0] SLOT_A = PW'(VOTE_MID - 1);
  localparam logic [PW-1:0] SLOT_B = PW'(VOTE_MID);
  localparam logic [PW-1:0] SLOT_C = PW'(VOTE_MID + 1);

  logic          busy, prev_s, s_a, s_b;
  logic [PW-1:0] phase;
  logic [3:0]    bitn;
  logic [8:0]    shreg;

  wire vote      = (s_a & s_b) | (s_a & rxd) | (s_b & rxd);
  wire decide    = busy && samp_en && (phase == SLOT_C);
  wire at_start  = (bitn == 4'd0);
  wire at_stop   = (bitn == (nine_bit ? 4'd10 : 4'd9));
  wire at_ninth  = nine_bit && (bitn == 4'd9);
  wire finish    = decide && (at_stop || (at_ninth && !frame_chk_en));
  wire mp_block  = at_stop && !nine_bit && multi_proc && !vote;
  wire deliver   = finish && !rx_ready && rx_enable && accept && !mp_block;
  wire bad_stop  = decide && at_stop && frame_chk_en && !vote;
  wire late      = nine_bit && at_stop;
  wire [7:0] new_byte = late ? shreg[7:0] : shreg[8:1];
  wire       new_b9   = late ? shreg[8]   : vote;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      prev_s <= 1'b1;
      s_a    <= 1'b1;
      s_b    <= 1'b1;
      phase  <= '0;
      bitn   <= 4'd0;
      shreg  <= 9'h1FF;
    end else begin
      if (samp_en) prev_s <= rxd;
      if (!busy) begin
        if (samp_en && rx_enable && prev_s && !rxd) begin
          busy  <= 1'b1;
          phase <= PW'(1);
          bitn  <= 4'd0;
          shreg <= 9'h1FF;
        end
      end else if (samp_en) begin
        phase <= phase + 1'b1;
        if (phase == SLOT_A) s_a <= rxd;
        if (phase == SLOT_B) s_b <= rxd;
        if (decide) begin
          if (at_start) begin
            if (vote) busy <= 1'b0;
            else      bitn <= 4'd1;
          end else if (finish) begin
            busy <= 1'b0;
          end else begin
            shreg <= {vote, shreg[8:1]};
            bitn  <= bitn + 4'd1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_byte   <= 8'h00;
      rx_bit9   <= 1'b0;
      rx_ready  <= 1'b0;
      frame_err <= 1'b0;
    end else begin
      if (clr_ri) rx_ready <= 1'b0;
      if (deliver) begin
        rx_ready <= 1'b1;
        rx_byte  <= new_byte;
        rx_bit9  <= new_b9;
      end
      if (clr_fe)   frame_err <= 1'b0;
      if (bad_stop) frame_err <= 1'b1;
    end
  end
endmodule

// File: rtl/rx_oversample_uart_chk.sv
module rx_oversample_uart_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_enable,
  input logic       frame_chk_en,
  input logic       accept,
  input logic       clr_ri,
  input logic       clr_fe,
  input logic [7:0] rx_byte,
  input logic       rx_bit9,
  input logic       rx_ready,
  input logic       frame_err
);
  p_fe_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err && !clr_fe |=> frame_err);
  p_fe_needs_chk_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_err) |-> $past(frame_chk_en));
  p_ri_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready && !clr_ri |=> rx_ready && $stable(rx_byte) && $stable(rx_bit9));
  p_ri_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ready) |-> $past(rx_enable) && $past(accept));
  p_byte_on_ri_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_byte) |-> $rose(rx_ready));
  p_ri_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    clr_ri && rx_ready |=> !rx_ready);
endmodule

bind rx_oversample_uart rx_oversample_uart_chk i_chk (
  .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .frame_chk_en(frame_chk_en),
  .accept(accept), .clr_ri(clr_ri), .clr_fe(clr_fe), .rx_byte(rx_byte),
  .rx_bit9(rx_bit9), .rx_ready(rx_ready), .frame_err(frame_err)
);

// File: tb/test_rx_oversample_uart.sv
`timescale 1ns/1ps
module test_rx_oversample_uart;
  logic clk = 0, rst_n = 0, samp_en = 0, rxd = 1;
  logic rx_enable = 1, multi_proc = 0, nine_bit = 0, frame_chk_en = 0, accept = 1;
  logic clr_ri = 0, clr_fe = 0;
  logic [7:0] rx_byte;
  logic rx_bit9, rx_ready, frame_err;
  int nchk = 0, nfail = 0;
  logic [7:0] last_byte;

  always #2 clk = ~clk;

  rx_oversample_uart i_rx_oversample_uart (
    .clk(clk), .rst_n(rst_n), .samp_en(samp_en), .rxd(rxd), .rx_enable(rx_enable),
    .multi_proc(multi_proc), .nine_bit(nine_bit), .frame_chk_en(frame_chk_en),
    .accept(accept), .clr_ri(clr_ri), .clr_fe(clr_fe), .rx_byte(rx_byte),
    .rx_bit9(rx_bit9), .rx_ready(rx_ready), .frame_err(frame_err)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input logic v);
    @(negedge clk); rxd = v; samp_en = 1;
    @(negedge clk); samp_en = 0;
  endtask

  task automatic bitx(input logic v, input int glitch);
    for (int t = 0; t < 16; t++) tick((t == glitch) ? ~v : v);
  endtask

  task automatic frame(input logic [8:0] d, input logic stopv, input int gbit, input int gtick);
    bitx(1'b0, (gbit == 0) ? gtick : -1);
    for (int i = 0; i < (nine_bit ? 9 : 8); i++) bitx(d[i], (gbit == i + 1) ? gtick : -1);
    bitx(stopv, -1);
    repeat (4) tick(1'b1);
  endtask

  task automatic ack_ri();
    @(negedge clk); clr_ri = 1;
    @(negedge clk); clr_ri = 0;
  endtask

  task automatic ack_fe();
    @(negedge clk); clr_fe = 1;
    @(negedge clk); clr_fe = 0;
  endtask

  initial begin
    #800000;
    nfail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 ready", rx_ready, 0);
    chk("R1 fe", frame_err, 0);
    chk("R1 byte", rx_byte, 0);
    chk("R1 bit9", rx_bit9, 0);

    nine_bit = 0;
    for (int v = 0; v < 256; v += 5) begin
      frame(9'(v), 1'b1, -1, 0);
      chk("R2 byte", rx_byte, v);
      chk("R2 stop in bit9", rx_bit9, 1);
      chk("R2 ready", rx_ready, 1);
      ack_ri();
      chk("R12 cleared", rx_ready, 0);
    end

    nine_bit = 1;
    for (int v = 3; v < 512; v += 11) begin
      frame(9'(v), 1'b1, -1, 0);
      chk("R3 byte", rx_byte, v & 255);
      chk("R3 ninth", rx_bit9, (v >> 8) & 1);
      chk("R3 ready", rx_ready, 1);
      ack_ri();
    end

    nine_bit = 0;
    frame(9'h0A5, 1'b1, 3, 8);
    chk("R5 slot8 glitch", rx_byte, 8'hA5);
    ack_ri();
    frame(9'h05A, 1'b1, 5, 7);
    chk("R5 slot7 glitch", rx_byte, 8'h5A);
    ack_ri();
    frame(9'h0C3, 1'b1, 8, 9);
    chk("R5 slot9 glitch", rx_byte, 8'hC3);
    ack_ri();
    frame(9'h03C, 1'b1, 0, 8);
    chk("R5 start glitch", rx_byte, 8'h3C);
    chk("R5 start glitch ready", rx_ready, 1);
    ack_ri();

    @(negedge clk); rxd = 0;
    @(negedge clk); rxd = 1;
    repeat (24) tick(1'b1);
    chk("R4 pulse between samples", rx_ready, 0);
    frame(9'h081, 1'b1, -1, 0);
    chk("R4 next frame", rx_byte, 8'h81);
    ack_ri();

    repeat (4) tick(1'b0);
    repeat (24) tick(1'b1);
    chk("R6 short false start", rx_ready, 0);
    repeat (8) tick(1'b0);
    repeat (24) tick(1'b1);
    chk("R6 false start slot7", rx_ready, 0);
    frame(9'h05A, 1'b1, -1, 0);
    chk("R6 recover byte", rx_byte, 8'h5A);
    chk("R6 recover ready", rx_ready, 1);
    ack_ri();

    frame_chk_en = 1;
    frame(9'h033, 1'b0, -1, 0);
    chk("R7 fe set", frame_err, 1);
    chk("R7 bit9 stop", rx_bit9, 0);
    ack_ri();
    frame(9'h044, 1'b1, -1, 0);
    chk("R7 fe sticky", frame_err, 1);
    chk("R7 good byte", rx_byte, 8'h44);
    ack_ri();
    ack_fe();
    chk("R7 fe cleared", frame_err, 0);
    nine_bit = 1;
    frame(9'h1EE, 1'b0, -1, 0);
    chk("R7 fe 9-bit", frame_err, 1);
    ack_ri();
    ack_fe();
    nine_bit = 0;

    frame_chk_en = 0;
    frame(9'h099, 1'b0, -1, 0);
    chk("R8 no fe", frame_err, 0);
    chk("R8 ready", rx_ready, 1);
    chk("R8 byte", rx_byte, 8'h99);
    chk("R8 bit9 stop", rx_bit9, 0);
    ack_ri();

    nine_bit = 1;
    for (int m = 0; m < 2; m++) begin
      frame_chk_en = logic'(m);
      bitx(1'b0, -1);
      for (int i = 0; i < 9; i++) bitx(logic'((9'h12D >> i) & 1), -1);
      repeat (4) tick(1'b1);
      chk("R9 ready early", rx_ready, (m == 0) ? 1 : 0);
      repeat (12) tick(1'b1);
      repeat (4) tick(1'b1);
      chk("R9 ready late", rx_ready, 1);
      chk("R9 byte", rx_byte, 8'h2D);
      chk("R9 ninth", rx_bit9, 1);
      ack_ri();
    end
    nine_bit = 0;
    frame_chk_en = 0;

    multi_proc = 1;
    frame(9'h077, 1'b0, -1, 0);
    chk("R10 bad stop no ready", rx_ready, 0);
    chk("R10 byte kept", rx_byte, 8'h2D);
    frame(9'h078, 1'b1, -1, 0);
    chk("R10 good stop ready", rx_ready, 1);
    chk("R10 byte", rx_byte, 8'h78);
    multi_proc = 0;

    last_byte = rx_byte;
    frame(9'h011, 1'b1, -1, 0);
    chk("R11 pending keeps byte", rx_byte, last_byte);
    chk("R11 pending ready", rx_ready, 1);
    ack_ri();
    rx_enable = 0;
    frame(9'h022, 1'b1, -1, 0);
    chk("R11 disabled ready", rx_ready, 0);
    chk("R11 disabled byte", rx_byte, last_byte);
    rx_enable = 1;
    accept = 0;
    frame(9'h0F0, 1'b1, -1, 0);
    chk("R11 not accepted ready", rx_ready, 0);
    chk("R11 not accepted byte", rx_byte, last_byte);
    accept = 1;
    frame(9'h00F, 1'b1, -1, 0);
    chk("R11 accepted byte", rx_byte, 8'h0F);
    ack_ri();
    chk("R12 final clear", rx_ready, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end
endmodule